// File: doc/BRIEF.md
# Register Rename Status Table

This block tracks, for every architectural register, the committed value together with a busy flag and the reorder-buffer tag of the newest instruction that will write it. An out-of-order core uses it at two points: at issue, and at in-order commit.

At issue it resolves two source operands into one of three outcomes, all in the same cycle:
- a register that is not busy returns its committed value;
- a busy register whose producer has already finished returns that result, forwarded from the reorder buffer;
- otherwise the producer's tag is returned, and the operand is pending.

The reorder buffer itself lies outside the block. It is reached through one combinational query port per operand, which sends out a tag and gets back a ready flag and a value. In the same cycle the table renames the destination register to the newly allocated tag. At commit the block writes the result into the register. It clears the busy flag only if the committing tag is still the newest producer. A flush after a misprediction drops all pending producers.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register holds zero and none is busy, so every lookup returns value 0 with pending low.
- R2: A source register that is not busy returns its committed value with pending low and tag output 0.
- R3: A busy source whose reorder-buffer entry reports ready returns that entry's value with pending low and tag output 0.
- R4: A busy source whose entry is not ready returns pending high, the producer tag on the tag output, and value 0. The query tag sent to the reorder buffer equals that producer tag.
- R5: An issue with iss_valid high marks the destination busy with iss_tag from the next cycle on. A later issue to the same register replaces the tag.
- R6: Lookups in an issue cycle use the state from before that issue's rename, so a source equal to the destination sees the older producer.
- R7: A commit writes cmt_val into cmt_dst. It clears busy when cmt_tag equals the register's current producer tag.
- R8: A commit whose tag is not the register's current producer still writes the value, but the register stays busy with the newer tag.
- R9: When an issue and a commit target the same register in one cycle, the register ends busy with the issued tag.
- R10: A flush clears busy and producer tags for all registers from the next cycle on. An issue in the flush cycle has no effect.
- R11: Register 0 always reads value 0, is never pending, and ignores both issue and commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue: rename the destination this cycle |
| iss_dst | input | IDX_W | Issue destination register |
| iss_tag | input | TAG_W | Reorder-buffer tag allocated to the issuing instruction |
| src_a | input | IDX_W | Source operand A register |
| src_b | input | IDX_W | Source operand B register |
| rob_qa_tag | output | TAG_W | Tag queried in the reorder buffer for operand A |
| rob_qa_rdy | input | 1 | Reorder-buffer entry for operand A has its result |
| rob_qa_val | input | DATA_W | Reorder-buffer result for operand A |
| rob_qb_tag | output | TAG_W | Tag queried in the reorder buffer for operand B |
| rob_qb_rdy | input | 1 | Reorder-buffer entry for operand B has its result |
| rob_qb_val | input | DATA_W | Reorder-buffer result for operand B |
| opa_val | output | DATA_W | Resolved operand A value |
| opa_pend | output | 1 | Operand A waits on a producer |
| opa_tag | output | TAG_W | Producer tag of operand A when pending, else 0 |
| opb_val | output | DATA_W | Resolved operand B value |
| opb_pend | output | 1 | Operand B waits on a producer |
| opb_tag | output | TAG_W | Producer tag of operand B when pending, else 0 |
| cmt_valid | input | 1 | Commit a result this cycle |
| cmt_dst | input | IDX_W | Committing register |
| cmt_tag | input | TAG_W | Tag of the committing instruction |
| cmt_val | input | DATA_W | Committed value |
| flush | input | 1 | Drop all pending producers |

## Verification
Operand results are combinational: they follow the sources and the reorder-buffer response in the same cycle, and they reflect the table as it stood before the current clock edge. The effects of issue, commit and flush appear one cycle later, once the table registers have updated.

The bench therefore drives each vector just after a falling edge and reads the operand outputs a quarter period later, before the next rising edge. A vector's own issue, commit or flush is judged by the lookups in the vector that follows it. This one-cycle offset is also what lets R6 be checked, since the source lookups in the issue cycle still see the older producer.

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NREG   = 32,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [IDX_W-1:0]  src_a,
  input  logic [IDX_W-1:0]  src_b,
  output logic [TAG_W-1:0]  rob_qa_tag,
  input  logic              rob_qa_rdy,
  input  logic [DATA_W-1:0] rob_qa_val,
  output logic [TAG_W-1:0]  rob_qb_tag,
  input  logic              rob_qb_rdy,
  input  logic [DATA_W-1:0] rob_qb_val,
  output logic [DATA_W-1:0] opa_val,
  output logic              opa_pend,
  output logic [TAG_W-1:0]  opa_tag,
  output logic [DATA_W-1:0] opb_val,
  output logic              opb_pend,
  output logic [TAG_W-1:0]  opb_tag,
  input  logic              cmt_valid,
  input  logic [IDX_W-1:0]  cmt_dst,
  input  logic [TAG_W-1:0]  cmt_tag,
  input  logic [DATA_W-1:0] cmt_val,
  input  logic              flush
);

  logic [DATA_W-1:0] regval [NREG];
  logic [TAG_W-1:0]  qtag   [NREG];
  logic [NREG-1:0]   busy;

  assign regval[0] = '0;
  assign qtag[0]   = '0;
  assign busy[0]   = 1'b0;

  for (genvar i = 1; i < NREG; i++) begin : g_ent
    wire hit_iss = iss_valid && (iss_dst == IDX_W'(i));
    wire hit_cmt = cmt_valid && (cmt_dst == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regval[i] <= '0;
        qtag[i]   <= '0;
        busy[i]   <= 1'b0;
      end else begin
        if (hit_cmt) regval[i] <= cmt_val;
        if (flush) begin
          busy[i] <= 1'b0;
          qtag[i] <= '0;
        end else if (hit_iss) begin
          busy[i] <= 1'b1;
          qtag[i] <= iss_tag;
        end else if (hit_cmt && qtag[i] == cmt_tag) begin
          busy[i] <= 1'b0;
        end
      end
    end
  end

  assign rob_qa_tag = qtag[src_a];
  assign rob_qb_tag = qtag[src_b];

  assign opa_pend = busy[src_a] && !rob_qa_rdy;
  assign opb_pend = busy[src_b] && !rob_qb_rdy;

  assign opa_tag = opa_pend ? qtag[src_a] : '0;
  assign opb_tag = opb_pend ? qtag[src_b] : '0;

  assign opa_val = !busy[src_a] ? regval[src_a] : (rob_qa_rdy ? rob_qa_val : '0);
  assign opb_val = !busy[src_b] ? regval[src_b] : (rob_qb_rdy ? rob_qb_val : '0);

endmodule

// File: rtl/rename_status_table_chk.sv
module rename_status_table_chk #(
  parameter int NREG   = 32,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic [IDX_W-1:0]  iss_dst,
  input logic              flush,
  input logic [NREG-1:0]   busy,
  input logic [IDX_W-1:0]  src_a,
  input logic [TAG_W-1:0]  rob_qa_tag,
  input logic              rob_qa_rdy,
  input logic [DATA_W-1:0] rob_qa_val,
  input logic [DATA_W-1:0] opa_val,
  input logic              opa_pend,
  input logic [TAG_W-1:0]  opa_tag
);

  assert_pend_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    opa_pend |-> (!rob_qa_rdy && opa_tag == rob_qa_tag && opa_val == '0));

  assert_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[src_a] && rob_qa_rdy) |-> (!opa_pend && opa_val == rob_qa_val));

  assert_issue_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !flush && iss_dst != '0) |=> busy[$past(iss_dst)]);

  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy == '0));

  assert_zero_reg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == '0) |-> (!opa_pend && opa_val == '0));

endmodule

bind rename_status_table rename_status_table_chk #(
  .NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
  .flush(flush), .busy(busy), .src_a(src_a), .rob_qa_tag(rob_qa_tag),
  .rob_qa_rdy(rob_qa_rdy), .rob_qa_val(rob_qa_val), .opa_val(opa_val),
  .opa_pend(opa_pend), .opa_tag(opa_tag)
);

// File: tb/rename_status_table_tb.sv
module rename_status_table_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 0, cmt_valid = 0, flush = 0;
  logic [4:0] iss_dst = 0, src_a = 0, src_b = 0, cmt_dst = 0;
  logic [3:0] iss_tag = 0, cmt_tag = 0;
  logic [DW-1:0] cmt_val = 0, rob_qa_val = 0, rob_qb_val = 0;
  logic rob_qa_rdy = 0, rob_qb_rdy = 0;
  logic [3:0] rob_qa_tag, rob_qb_tag, opa_tag, opb_tag;
  logic [DW-1:0] opa_val, opb_val;
  logic opa_pend, opb_pend;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rename_status_table #(.NREG(32), .TAG_W(4), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .src_a(src_a), .src_b(src_b),
    .rob_qa_tag(rob_qa_tag), .rob_qa_rdy(rob_qa_rdy), .rob_qa_val(rob_qa_val),
    .rob_qb_tag(rob_qb_tag), .rob_qb_rdy(rob_qb_rdy), .rob_qb_val(rob_qb_val),
    .opa_val(opa_val), .opa_pend(opa_pend), .opa_tag(opa_tag),
    .opb_val(opb_val), .opb_pend(opb_pend), .opb_tag(opb_tag),
    .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_tag(cmt_tag), .cmt_val(cmt_val),
    .flush(flush)
  );

  typedef struct packed {
    logic iv; logic [4:0] idst; logic [3:0] itag;
    logic cv; logic [4:0] cdst; logic [3:0] ctag; logic [15:0] cval;
    logic fl; logic [4:0] sa; logic [4:0] sb;
    logic ardy; logic [15:0] aval; logic brdy; logic [15:0] bval;
    logic epa; logic [3:0] eta; logic [15:0] eva;
    logic epb; logic [3:0] etb; logic [15:0] evb;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // R1 reset state
    '{0,0,0, 0,0,0,16'h0, 0, 3,0, 0,16'h0,0,16'h0, 0,0,16'h0, 0,0,16'h0, 1},
    // R2 commit r3 while not busy
    '{0,0,0, 1,3,2,16'h1111, 0, 3,0, 0,16'h0,0,16'h0, 0,0,16'h0, 0,0,16'h0, 2},
    // R6 issue r3 tag5, same-cycle lookup sees committed 1111
    '{1,3,5, 0,0,0,16'h0, 0, 3,3, 0,16'h0,0,16'h0, 0,0,16'h1111, 0,0,16'h1111, 6},
    // R4 a pending tag5; R3 b forwarded BEEF; issue r4 tag6
    '{1,4,6, 0,0,0,16'h0, 0, 3,3, 0,16'h0,1,16'hBEEF, 1,5,16'h0, 0,0,16'hBEEF, 4},
    // R5 issue r3 tag7; check r4 tag6, r3 tag5
    '{1,3,7, 0,0,0,16'h0, 0, 4,3, 0,16'h0,0,16'h0, 1,6,16'h0, 1,5,16'h0, 5},
    // R5 r3 now tag7; stale commit r3 tag5
    '{0,0,0, 1,3,5,16'h2222, 0, 3,0, 0,16'h0,0,16'h0, 1,7,16'h0, 0,0,16'h0, 5},
    // R8 r3 still busy tag7; commit r4 tag6
    '{0,0,0, 1,4,6,16'h4444, 0, 3,3, 0,16'h0,1,16'h7777, 1,7,16'h0, 0,0,16'h7777, 8},
    // R7 r4 cleared with 4444; issue r3 tag9 + commit r3 tag7 same cycle
    '{1,3,9, 1,3,7,16'h3333, 0, 4,3, 0,16'h0,0,16'h0, 0,0,16'h4444, 1,7,16'h0, 7},
    // R9 r3 busy tag9; issue r5 tag10
    '{1,5,10, 0,0,0,16'h0, 0, 3,0, 0,16'h0,0,16'h0, 1,9,16'h0, 0,0,16'h0, 9},
    // R10 flush with issue r6 tag11; r5 pending tag10
    '{1,6,11, 0,0,0,16'h0, 1, 5,0, 0,16'h0,0,16'h0, 1,10,16'h0, 0,0,16'h0, 10},
    // R10 r3 shows 3333, r5 reads 0
    '{0,0,0, 0,0,0,16'h0, 0, 3,5, 0,16'h0,0,16'h0, 0,0,16'h3333, 0,0,16'h0, 10},
    // R10 r6 not renamed; R11 issue and commit to r0
    '{1,0,3, 1,0,0,16'hDEAD, 0, 6,0, 0,16'h0,0,16'h0, 0,0,16'h0, 0,0,16'h0, 10},
    // R11 r0 reads zero despite rob ready
    '{0,0,0, 0,0,0,16'h0, 0, 0,0, 1,16'h5555,1,16'h1234, 0,0,16'h0, 0,0,16'h0, 11}
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    iss_valid = 0; cmt_valid = 0; flush = 0;
    rob_qa_rdy = 0; rob_qb_rdy = 0; rob_qa_val = 0; rob_qb_val = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      vec_t v = VEC[k];
      string rq = $sformatf("R%0d", v.req);
      @(negedge clk);
      iss_valid = v.iv; iss_dst = v.idst; iss_tag = v.itag;
      cmt_valid = v.cv; cmt_dst = v.cdst; cmt_tag = v.ctag; cmt_val = v.cval;
      flush = v.fl; src_a = v.sa; src_b = v.sb;
      rob_qa_rdy = v.ardy; rob_qa_val = v.aval; rob_qb_rdy = v.brdy; rob_qb_val = v.bval;
      #5;
      chk(rq, "a pend", 16'(opa_pend), 16'(v.epa));
      chk(rq, "a tag",  16'(opa_tag),  16'(v.eta));
      chk(rq, "a val",  opa_val,       v.eva);
      chk(rq, "b pend", 16'(opb_pend), 16'(v.epb));
      chk(rq, "b tag",  16'(opb_tag),  16'(v.etb));
      chk(rq, "b val",  opb_val,       v.evb);
    end
    // R4 query tag seen by the reorder buffer
    @(negedge clk); idle(); iss_valid = 1; iss_dst = 7; iss_tag = 4'hC;
    @(negedge clk); idle(); src_a = 7; src_b = 7;
    #5;
    chk("R4", "query tag", 16'(rob_qa_tag), 16'hC);
    chk("R4", "pend tag", 16'(opa_tag), 16'hC);
    // R1 reset clears pending state and values
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; src_a = 7; src_b = 3;
    #5;
    chk("R1", "r7 pend", 16'(opa_pend), 16'h0);
    chk("R1", "r3 val", opb_val, 16'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule